// File: doc/BRIEF.md
# Serial Flash Read Controller

This block reads a run of consecutive bytes from a NOR flash over a single-lane SPI link. A request holds a 24-bit start address, a byte count and a mode bit. The mode bit picks a plain read or a fast read. The engine lowers chip select and clocks out the one-byte command and the address. In fast mode it also clocks out one dummy byte. It then keeps clocking until the requested number of bytes has come back. The flash advances its own address after every byte, so one command covers the whole run. The start address may be any byte, with no alignment.

The serial clock comes from dividing the system clock. The half-period is a parameter, and the slow plain read uses a larger one than the fast read. Received bytes leave on a valid/ready stream. If the consumer stalls, the serial clock stops between bytes, with chip select still low. A flash-busy input stops a read from starting while the flash is in a write or erase cycle. After each run chip select stays high for a minimum time. A one-cycle done pulse closes every request.

Top module: `flash_read_engine`

## Requirements
- R1: After reset, spi_cs_n is high, spi_sck is low, out_valid and done are low, and req_ready is high while flash_busy is low.
- R2: The first 8 bits sent on spi_mosi after chip select falls are the command, most significant bit first. The command is 0x03 when req_fast is 0 and 0x0B when req_fast is 1.
- R3: The 24 bits that follow the command are req_addr, bit 23 first. Any start address is sent unchanged, including addresses that are not aligned.
- R4: In fast mode, 8 dummy clocks with spi_mosi low come after the address. Plain mode has none. A request for N bytes therefore gives exactly 32+8N rising edges in plain mode and 40+8N in fast mode.
- R5: While chip select is low, spi_mosi changes only in the cycle where spi_sck falls, and spi_miso is sampled on rising edges. spi_sck stays low whenever chip select is high.
- R6: Each returned byte is assembled from spi_miso, most significant bit first. Exactly N bytes appear on out_data, in the order the flash sends them.
- R7: While out_valid is high and out_ready is low, out_data holds its value. Once a byte is complete and not yet taken, no further rising edge occurs, and chip select stays low.
- R8: While flash_busy is high, req_ready is low and chip select does not fall.
- R9: Each serial clock half-period lasts HALF_SLOW system clocks in plain mode and HALF_FAST in fast mode, with HALF_SLOW greater than HALF_FAST.
- R10: Chip select falls at least one system clock before the first rising edge. It rises only after the last rising edge, with spi_sck low. It then stays high for at least CS_GAP system clocks before it can fall again.
- R11: done is a single-cycle pulse, given once for each accepted request. A request with a count of zero gives done without lowering chip select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_addr | input | 24 | Start byte address |
| req_len | input | LEN_W | Number of bytes to read |
| req_fast | input | 1 | 1 selects fast read with dummy byte |
| flash_busy | input | 1 | Flash is in a write or erase cycle |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |
| out_valid | output | 1 | Received byte available |
| out_data | output | 8 | Received byte |
| out_ready | input | 1 | Consumer takes the byte |
| done | output | 1 | One-cycle end-of-request pulse |

## Verification
The bench contains a flash model that decodes the command and the address from spi_mosi. The model answers with a byte pattern computed from the address. The engine is run in plain and fast mode, at an aligned address, at an odd address and at an address just below the top of the array. The run lengths are one byte and several bytes. Together these separate the two commands, show whether the dummy byte is present, and show how many edges one run needs.

The consumer is tested three ways: always ready, ready in a pseudo-random pattern, and ready held low for a long time. The last case shows whether the clock really stops at a byte boundary and whether any byte is lost or repeated. Further runs raise flash-busy during a request, send back-to-back requests to check the chip-select gap, and send a zero-length request.

// File: rtl/frd_pkg.sv
// Package: shared constants and the sequencer state type of the flash read engine.
// Assumes single-lane SPI mode 0 and a 3-byte address.
package frd_pkg;
    localparam logic [7:0] OPC_PLAIN = 8'h03;
    localparam logic [7:0] OPC_QUICK = 8'h0B;
    localparam int         ADDR_BITS = 24;
    localparam int         HDR_PLAIN = 8 + ADDR_BITS;
    localparam int         HDR_QUICK = 8 + ADDR_BITS + 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_SHIFT = 2'd2,
        ST_GAP   = 2'd3
    } frd_state_e;
endpackage

// File: rtl/frd_sck_gen.sv
// Module: serial clock generator.
// Divides clk by 2*half while run is high. The clock is frozen while hold is high,
// and the caller raises hold only while sck is low. rise_tick and fall_tick flag the
// cycle whose clock edge toggles sck. Assumes half >= 1.
module frd_sck_gen #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             hold,
    input  logic [DIV_W-1:0] half,
    output logic             sck,
    output logic             rise_tick,
    output logic             fall_tick
);
    logic [DIV_W-1:0] cnt;
    logic             wrap;

    // End of the current half-period.
    assign wrap      = run && !hold && (cnt == half - 1'b1);
    assign rise_tick = wrap && !sck;
    assign fall_tick = wrap && sck;

    // Half-period counter and clock toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            sck <= 1'b0;
        end else if (!run) begin
            cnt <= '0;
            sck <= 1'b0;
        end else if (hold) begin
            cnt <= cnt;
        end else if (wrap) begin
            cnt <= '0;
            sck <= ~sck;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/frd_tx_shreg.sv
// Module: command shifter.
// Holds command, address and a zero dummy byte. It shifts left once per falling-edge
// tick, so the MSB on mosi changes only in the cycle where sck falls. After the header
// has gone out, only zeros remain, so mosi stays low through the data phase.
module frd_tx_shreg
    import frd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic                 fast,
    input  logic [ADDR_BITS-1:0] addr,
    input  logic                 shift,
    output logic                 mosi
);
    localparam int SR_W = HDR_QUICK;

    logic [SR_W-1:0] sr;

    assign mosi = sr[SR_W-1];

    // Load the header on accept, then shift it out MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr <= '0;
        end else if (load) begin
            sr <= {(fast ? OPC_QUICK : OPC_PLAIN), addr, 8'h00};
        end else if (shift) begin
            sr <= {sr[SR_W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/frd_rx_shreg.sv
// Module: byte assembler and output holding register.
// Shifts spi_miso in MSB first on each sample strobe. On the eighth bit it moves the
// byte to the output register and raises valid. valid drops when take is seen.
// Assumes the caller never completes a byte while the previous byte is still held.
module frd_rx_shreg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       sample,
    input  logic       miso,
    input  logic       take,
    output logic [7:0] data,
    output logic       valid,
    output logic       boundary,
    output logic       byte_pulse
);
    logic [6:0] acc;
    logic [2:0] bcnt;

    assign boundary   = (bcnt == 3'd0);
    assign byte_pulse = sample && (bcnt == 3'd7);

    // Bit accumulation and bit-in-byte count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc  <= '0;
            bcnt <= '0;
        end else if (sample) begin
            acc  <= {acc[5:0], miso};
            bcnt <= bcnt + 1'b1;
        end
    end

    // Output holding register with valid/ready handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data  <= '0;
            valid <= 1'b0;
        end else if (byte_pulse) begin
            data  <= {acc, miso};
            valid <= 1'b1;
        end else if (valid && take) begin
            valid <= 1'b0;
        end
    end
endmodule

// File: rtl/flash_read_engine.sv
// Module: serial flash read controller (top).
// Takes one request and runs one read command with chip select held low. It streams
// req_len bytes out and then keeps chip select high for CS_GAP clocks. Assumes
// HALF_SLOW > HALF_FAST >= 1 and CS_GAP >= 1. No request is taken while the flash
// reports busy or while a byte is still waiting to be taken.
module flash_read_engine
    import frd_pkg::*;
#(
    parameter int LEN_W     = 12,
    parameter int HALF_SLOW = 4,
    parameter int HALF_FAST = 2,
    parameter int CS_GAP    = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [ADDR_BITS-1:0] req_addr,
    input  logic [LEN_W-1:0]     req_len,
    input  logic                 req_fast,
    input  logic                 flash_busy,
    output logic                 spi_cs_n,
    output logic                 spi_sck,
    output logic                 spi_mosi,
    input  logic                 spi_miso,
    output logic                 out_valid,
    output logic [7:0]           out_data,
    input  logic                 out_ready,
    output logic                 done
);
    localparam int DIV_W = $clog2(HALF_SLOW) + 1;
    localparam int HDR_W = $clog2(HDR_QUICK + 1);
    localparam int GAP_W = $clog2(CS_GAP + 1) + 1;
    localparam logic [DIV_W-1:0] HALF_S   = DIV_W'(HALF_SLOW);
    localparam logic [DIV_W-1:0] HALF_F   = DIV_W'(HALF_FAST);
    localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(CS_GAP - 1);

    frd_state_e       state;
    logic             fast_q;
    logic [LEN_W-1:0] rem;
    logic [HDR_W-1:0] hdr_left;
    logic             in_data;
    logic             got_byte;
    logic             last_q;
    logic             cs_n_q;
    logic             done_q;
    logic [GAP_W-1:0] gap_cnt;

    logic             accept;
    logic             start;
    logic             run;
    logic             hold;
    logic [DIV_W-1:0] half;
    logic             rise_tick;
    logic             fall_tick;
    logic             rx_boundary;
    logic             byte_pulse;

    assign req_ready = (state == ST_IDLE) && !flash_busy && !out_valid;
    assign accept    = req_valid && req_ready;
    assign start     = accept && (req_len != '0);
    assign run       = (state == ST_SHIFT);
    assign half      = fast_q ? HALF_F : HALF_S;
    // Stop the clock at a byte boundary while the previous byte is still held.
    assign hold      = in_data && got_byte && rx_boundary && out_valid && !spi_sck;
    assign spi_cs_n  = cs_n_q;
    assign done      = done_q;

    frd_sck_gen #(.DIV_W(DIV_W)) u_sck (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .hold      (hold),
        .half      (half),
        .sck       (spi_sck),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    frd_tx_shreg u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (start),
        .fast  (req_fast),
        .addr  (req_addr),
        .shift (fall_tick),
        .mosi  (spi_mosi)
    );

    frd_rx_shreg u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (start),
        .sample     (rise_tick && in_data),
        .miso       (spi_miso),
        .take       (out_ready),
        .data       (out_data),
        .valid      (out_valid),
        .boundary   (rx_boundary),
        .byte_pulse (byte_pulse)
    );

    // Request sequencer: accept, header, data phase, chip-select gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            fast_q   <= 1'b0;
            rem      <= '0;
            hdr_left <= '0;
            in_data  <= 1'b0;
            got_byte <= 1'b0;
            last_q   <= 1'b0;
            cs_n_q   <= 1'b1;
            done_q   <= 1'b0;
            gap_cnt  <= '0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept && !start) begin
                        done_q <= 1'b1;
                    end else if (start) begin
                        state    <= ST_SETUP;
                        cs_n_q   <= 1'b0;
                        fast_q   <= req_fast;
                        rem      <= req_len;
                        hdr_left <= req_fast ? HDR_W'(HDR_QUICK) : HDR_W'(HDR_PLAIN);
                        in_data  <= 1'b0;
                        got_byte <= 1'b0;
                        last_q   <= 1'b0;
                    end
                end
                ST_SETUP: begin
                    state <= ST_SHIFT;
                end
                ST_SHIFT: begin
                    if (rise_tick && !in_data) begin
                        hdr_left <= hdr_left - 1'b1;
                        if (hdr_left == HDR_W'(1)) begin
                            in_data <= 1'b1;
                        end
                    end else if (byte_pulse) begin
                        got_byte <= 1'b1;
                        rem      <= rem - 1'b1;
                        if (rem == LEN_W'(1)) begin
                            last_q <= 1'b1;
                        end
                    end
                    if (fall_tick && last_q) begin
                        state   <= ST_GAP;
                        cs_n_q  <= 1'b1;
                        done_q  <= 1'b1;
                        gap_cnt <= '0;
                    end
                end
                ST_GAP: begin
                    if (gap_cnt == GAP_LAST) begin
                        state <= ST_IDLE;
                    end else begin
                        gap_cnt <= gap_cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/frd_checker.sv
// Module: protocol checker for flash_read_engine, attached by bind.
// It watches only the ports of the top module.
module frd_checker #(
    parameter int CS_GAP = 3
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       sck,
    input logic       mosi,
    input logic       flash_busy,
    input logic       out_valid,
    input logic [7:0] out_data,
    input logic       out_ready,
    input logic       done
);
    localparam int HC_W = $clog2(CS_GAP + 1) + 1;

    logic [HC_W-1:0] hi_cnt;

    // Count the cycles chip select has been high, saturating at CS_GAP.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt <= HC_W'(CS_GAP);
        end else if (!cs_n) begin
            hi_cnt <= '0;
        end else if (hi_cnt < HC_W'(CS_GAP)) begin
            hi_cnt <= hi_cnt + 1'b1;
        end
    end

    a_r5_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck);

    a_r5_mosi_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && $past(!cs_n) && !$fell(sck)) |-> $stable(mosi));

    a_r7_data_held: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    a_r8_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> $past(!flash_busy));

    a_r10_release_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> !sck);

    a_r10_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> ($past(hi_cnt) >= HC_W'(CS_GAP)));

    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind flash_read_engine frd_checker #(.CS_GAP(CS_GAP)) u_frd_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (spi_cs_n),
    .sck        (spi_sck),
    .mosi       (spi_mosi),
    .flash_busy (flash_busy),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_ready  (out_ready),
    .done       (done)
);

// File: tb/sim_flash_read_engine.sv
// Directed bench for flash_read_engine with a cycle-sampled flash model.
module sim_flash_read_engine;
    localparam int LW  = 12;
    localparam int HS  = 4;
    localparam int HF  = 2;
    localparam int GAP = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [23:0]   req_addr = '0;
    logic [LW-1:0] req_len = '0;
    logic          req_fast = 1'b0;
    logic          flash_busy = 1'b0;
    logic          spi_cs_n, spi_sck, spi_mosi;
    logic          spi_miso = 1'b0;
    logic          out_valid;
    logic [7:0]    out_data;
    logic          out_ready = 1'b1;
    logic          done;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int rdy_mode = 0;

    // flash model and monitor state
    logic       p_sck = 1'b0, p_cs = 1'b1, p_mosi = 1'b0, p_done = 1'b0;
    logic [7:0] opc = '0;
    logic [23:0] adr = '0;
    int bitcnt = 0, rises = 0, first_rise = 0, second_rise = 0, last_rise = 0;
    int cs_fall_cyc = 0, cs_rise_cyc = 0, last_gap = 0, cs_falls = 0;
    int mosi_bad = 0, dummy_bad = 0, sck_hi_rel = 0, done_cnt = 0, done_hi = 0;
    int ngot = 0;
    logic [7:0] got [0:63];

    flash_read_engine #(.LEN_W(LW), .HALF_SLOW(HS), .HALF_FAST(HF), .CS_GAP(GAP)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .req_fast(req_fast),
        .flash_busy(flash_busy), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .out_valid(out_valid),
        .out_data(out_data), .out_ready(out_ready), .done(done)
    );

    always #4 clk = ~clk;

    function automatic logic [7:0] mem_at(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hA5;
    endfunction

    task automatic chk(input string tag, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // cycle counter
    initial forever begin
        @(posedge clk);
        cyc = cyc + 1;
    end

    // consumer ready driver, changed just after each rising clock edge
    initial begin
        logic [15:0] lf;
        lf = 16'hACE1;
        forever begin
            @(posedge clk);
            #2;
            case (rdy_mode)
                0: out_ready = 1'b1;
                1: begin
                    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                    out_ready = lf[0];
                end
                default: out_ready = 1'b0;
            endcase
        end
    end

    // flash model and monitor, sampled on the falling system clock edge
    initial forever begin
        int hdr, idx;
        logic [7:0] b;
        @(negedge clk);
        if (p_cs && !spi_cs_n) begin
            cs_falls++;
            last_gap = cyc - cs_rise_cyc;
            cs_fall_cyc = cyc;
            bitcnt = 0; rises = 0; opc = '0; adr = '0;
        end else if (!spi_cs_n && (spi_mosi !== p_mosi) && !(p_sck && !spi_sck)) begin
            mosi_bad++;
        end
        if (!spi_cs_n && !p_sck && spi_sck) begin
            if (rises == 0) first_rise = cyc;
            if (rises == 1) second_rise = cyc;
            rises++;
            last_rise = cyc;
            if (bitcnt < 8) opc = {opc[6:0], spi_mosi};
            else if (bitcnt < 32) adr = {adr[22:0], spi_mosi};
            else if (opc == 8'h0B && bitcnt < 40 && spi_mosi) dummy_bad++;
            bitcnt++;
        end
        if (!spi_cs_n && p_sck && !spi_sck) begin
            hdr = (opc == 8'h0B) ? 40 : 32;
            if (bitcnt >= hdr) begin
                idx = bitcnt - hdr;
                b = mem_at(adr + 24'(idx / 8));
                spi_miso = b[7 - (idx % 8)];
            end
        end
        if (!p_cs && spi_cs_n) begin
            cs_rise_cyc = cyc;
            if (spi_sck) sck_hi_rel++;
        end
        if (done) begin
            done_hi++;
            if (!p_done) done_cnt++;
        end
        if (out_valid && out_ready) begin
            if (ngot < 64) got[ngot] = out_data;
            ngot++;
        end
        p_sck = spi_sck; p_cs = spi_cs_n; p_mosi = spi_mosi; p_done = done;
    end

    task automatic send(input logic [23:0] a, input int n, input logic f);
        @(negedge clk);
        req_addr = a; req_len = LW'(n); req_fast = f; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done(input int d0);
        while (done_cnt == d0) @(posedge clk);
    endtask

    task automatic check_bytes(input logic [23:0] a, input int n, input string tag);
        int errs;
        errs = 0;
        for (int i = 0; i < n; i++)
            if (got[i] !== mem_at(a + 24'(i))) errs++;
        chk({tag, " R6 byte count"}, ngot, n);
        chk({tag, " R6 byte values"}, errs, 0);
    endtask

    // Full transfer with header, timing and data checks.
    task automatic t_xfer(input logic [23:0] a, input int n, input logic f,
                          input int mode, input string tag);
        int d0, hdr;
        rdy_mode = mode;
        d0 = done_cnt;
        ngot = 0;
        hdr = f ? 40 : 32;
        send(a, n, f);
        wait_done(d0);
        rdy_mode = 0;
        repeat (20) @(negedge clk);
        chk({tag, " R2 opcode"}, opc, f ? 8'h0B : 8'h03);
        chk({tag, " R3 address"}, adr, a);
        chk({tag, " R4 rising edges"}, rises, hdr + 8 * n);
        chk({tag, " R4 dummy low"}, dummy_bad, 0);
        chk({tag, " R5 mosi only on fall"}, mosi_bad, 0);
        chk({tag, " R9 clock period"}, second_rise - first_rise, 2 * (f ? HF : HS));
        chk({tag, " R10 cs setup"}, (first_rise - cs_fall_cyc) >= 1, 1);
        chk({tag, " R10 release after last edge"}, cs_rise_cyc > last_rise, 1);
        chk({tag, " R10 release with sck low"}, sck_hi_rel, 0);
        chk({tag, " R11 one done"}, done_cnt - d0, 1);
        check_bytes(a, n, tag);
    endtask

    task automatic t_reset;
        chk("R1 cs_n", spi_cs_n, 1);
        chk("R1 sck", spi_sck, 0);
        chk("R1 out_valid", out_valid, 0);
        chk("R1 done", done, 0);
        chk("R1 req_ready", req_ready, 1);
    endtask

    // Consumer stalled: the clock must stop after the first byte.
    task automatic t_stall;
        int d0;
        logic [7:0] held;
        logic [23:0] a;
        a = 24'h00A0F1;
        rdy_mode = 2;
        d0 = done_cnt;
        ngot = 0;
        send(a, 3, 1'b1);
        while (!out_valid) @(negedge clk);
        held = out_data;
        repeat (60) @(negedge clk);
        chk("R7 clock paused", rises, 40 + 8);
        chk("R7 data held", out_data, held);
        chk("R7 first byte", held, mem_at(a));
        chk("R7 cs still low", spi_cs_n, 0);
        rdy_mode = 0;
        wait_done(d0);
        repeat (20) @(negedge clk);
        check_bytes(a, 3, "R7 after stall");
    endtask

    // Flash busy blocks the start of a request.
    task automatic t_busy;
        int seen, f0;
        seen = 0;
        f0 = cs_falls;
        @(negedge clk);
        flash_busy = 1'b1;
        req_addr = 24'h111111; req_len = LW'(2); req_fast = 1'b0; req_valid = 1'b1;
        repeat (20) begin
            @(negedge clk);
            if (req_ready) seen++;
        end
        req_valid = 1'b0;
        chk("R8 ready low while busy", seen, 0);
        chk("R8 no chip select", cs_falls - f0, 0);
        flash_busy = 1'b0;
        repeat (3) @(negedge clk);
        t_xfer(24'h111111, 2, 1'b0, 0, "R8 after busy");
    endtask

    // Zero-length request: done without chip select activity.
    task automatic t_zero;
        int d0, f0;
        d0 = done_cnt;
        f0 = cs_falls;
        send(24'h000100, 0, 1'b0);
        repeat (5) @(negedge clk);
        chk("R11 zero length done", done_cnt - d0, 1);
        chk("R11 zero length no cs", cs_falls - f0, 0);
    endtask

    // Back-to-back requests respect the chip select gap.
    task automatic t_gap;
        int d0;
        d0 = done_cnt;
        ngot = 0;
        rdy_mode = 0;
        send(24'h000200, 1, 1'b1);
        wait_done(d0);
        send(24'h000300, 1, 1'b1);
        wait_done(d0 + 1);
        repeat (10) @(negedge clk);
        chk("R10 cs high gap", last_gap >= GAP, 1);
        chk("R11 two dones", done_cnt - d0, 2);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_xfer(24'h012345, 5, 1'b0, 0, "plain");
        t_xfer(24'hFFFFFE, 4, 1'b1, 0, "fast wrap");
        t_xfer(24'h000007, 1, 1'b0, 0, "plain single");
        t_xfer(24'h5A5A5B, 9, 1'b1, 1, "fast random ready");
        t_stall();
        t_busy();
        t_zero();
        t_gap();
        chk("R11 done width", done_hi, done_cnt);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=finish", cyc);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule